// File: doc/BRIEF.md
# Indexed Peripheral Clock-Gate Controller

This block keeps a 64-bit map of peripheral clock-disable bits. Each bit belongs to one peripheral address slot, and a 1 stops that peripheral's clock. Software can change one bit at a time by writing an encoded bit index to a set lane or a clear lane of a write-only command word. This needs no read-modify-write. A flag bit in the command byte makes it act on the whole map.

The same map can also be read and written directly as two 32-bit words, with byte enables. The block drives 64 registered clock-enable outputs, each the inverse of its map bit, toward the clock-gating cells elsewhere on the chip.

Only supervisor-mode writes change state. A user-mode write is dropped and raises a one-cycle access-error pulse.

Top module: `clkgate_map_ctl`

## Requirements
- R1: After reset the map reads all zeros, every `clk_en` bit is 1 and `acc_err` is 0.
- R2: A supervisor write to word address 2 with `bus_be[0]` set uses byte 0 as a set command. If its bit 6 is 0, bits 5..0 give an index 0..63, and only that map bit becomes 1.
- R3: A supervisor write to word address 2 with `bus_be[1]` set uses byte 1 (bits 15..8) as a clear command. If its bit 6 (bus bit 14) is 0, only the map bit named by bits 13..8 becomes 0.
- R4: When bit 6 of a command byte is 1, its index is ignored. A set command then sets all 64 bits, and a clear command clears all 64 bits.
- R5: Bit 7 of a command byte has no effect, and a command lane whose byte enable is 0 has no effect.
- R6: Reading word address 2, or any address above it, returns zero. Word address 0 reads map bits 31..0, and word address 1 reads map bits 63..32.
- R7: A supervisor write to word address 0 or 1 replaces each map byte whose byte enable is 1 and leaves the other bytes unchanged.
- R8: A user-mode write (`bus_sup`=0) to addresses 0..2 leaves the map unchanged. It drives `acc_err` high for exactly the next cycle. Supervisor writes never raise `acc_err`.
- R9: When both lanes are written in one cycle, the clear command wins for every bit that both commands touch.
- R10: `clk_en` equals the bitwise inverse of the map, delayed by one clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Word address (0 map low, 1 map high, 2 command word) |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables for the write |
| bus_we | input | 1 | Write strobe |
| bus_sup | input | 1 | 1 for a supervisor access, 0 for a user access |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| clk_en | output | 64 | Per-peripheral clock enables, 1 means running |
| acc_err | output | 1 | One-cycle pulse after a rejected user-mode write |

## Verification
The assertions check every cycle that:
- a single-index set or clear lands on the named bit;
- a global clear empties the map;
- the clear lane wins over the set lane;
- user writes leave the map unchanged and raise the error pulse;
- the command word reads as zero;
- the enables follow the inverted map one cycle later.

Some behaviour only the bench scenarios can show. These are that the bits next to an indexed bit stay unchanged, that reserved bit 7 and disabled lanes are ignored, that byte-enabled direct writes merge correctly, and that the full 64-bit map has the right value after a chain of mixed commands.

// File: rtl/cgm_pkg.sv
package cgm_pkg;
   // Which register a bus address selects
   typedef enum logic [1:0] {
      RS_NONE = 2'd0,
      RS_MAP  = 2'd1,
      RS_CMD  = 2'd2
   } reg_sel_e;

   // Byte lanes of the command word
   localparam int unsigned SET_LANE = 0;
   localparam int unsigned CLR_LANE = 1;
   localparam int unsigned CMD_W    = 8;
endpackage

// File: rtl/cgm_cmd_decode.sv
module cgm_cmd_decode #(
   parameter int unsigned MAP_W = 64,
   parameter int unsigned CMD_W = 8
) (
   input  logic             en_i,
   input  logic [CMD_W-1:0] cmd_i,
   output logic [MAP_W-1:0] mask_o
);
   localparam int unsigned IDX_W   = $clog2(MAP_W);
   localparam int unsigned ALL_BIT = IDX_W;

   initial begin
      if (MAP_W != (1 << IDX_W))
         $error("cgm_cmd_decode: MAP_W must be a power of two");
      if (CMD_W < IDX_W + 1)
         $error("cgm_cmd_decode: command byte too narrow for index plus flag");
   end

   logic             all_flag;
   logic [IDX_W-1:0] idx;

   assign all_flag = cmd_i[ALL_BIT];
   assign idx      = cmd_i[IDX_W-1:0];

   // One decoder slice per map bit; the global flag overrides the index
   for (genvar i = 0; i < MAP_W; i++) begin : g_bit
      assign mask_o[i] = en_i & (all_flag | (idx == IDX_W'(i)));
   end
endmodule

// File: rtl/cgm_map_reg.sv
module cgm_map_reg #(
   parameter int unsigned MAP_W    = 64,
   parameter int unsigned WORD_W   = 32,
   parameter bit          CLR_WINS = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [MAP_W/WORD_W-1:0]  wr_word_en_i,
   input  logic [WORD_W/8-1:0]      wr_be_i,
   input  logic [WORD_W-1:0]        wr_data_i,
   input  logic [MAP_W-1:0]         set_mask_i,
   input  logic [MAP_W-1:0]         clr_mask_i,
   output logic [MAP_W-1:0]         map_o
);
   localparam int unsigned N_WORDS = MAP_W / WORD_W;
   localparam int unsigned BE_W    = WORD_W / 8;

   initial begin
      if (MAP_W % WORD_W != 0)
         $error("cgm_map_reg: MAP_W must be a multiple of WORD_W");
      if (WORD_W % 8 != 0)
         $error("cgm_map_reg: WORD_W must be whole bytes");
   end

   logic [MAP_W-1:0] map_q;
   logic [MAP_W-1:0] direct_nxt;
   logic [MAP_W-1:0] map_nxt;

   // Direct byte-lane writes first
   always_comb begin
      direct_nxt = map_q;
      for (int w = 0; w < N_WORDS; w++) begin
         for (int b = 0; b < BE_W; b++) begin
            if (wr_word_en_i[w] && wr_be_i[b])
               direct_nxt[w*WORD_W + b*8 +: 8] = wr_data_i[b*8 +: 8];
         end
      end
   end

   // Commands override direct writes; the variant picks set/clear priority
   if (CLR_WINS) begin : g_clr_wins
      assign map_nxt = (direct_nxt | set_mask_i) & ~clr_mask_i;
   end else begin : g_set_wins
      assign map_nxt = (direct_nxt & ~clr_mask_i) | set_mask_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) map_q <= '0;
      else        map_q <= map_nxt;
   end

   assign map_o = map_q;

   if (CLR_WINS) begin : g_chk_clr
      assert_clear_wins_R9 : assert property (@(posedge clk) disable iff (!rst_n)
         ((set_mask_i & clr_mask_i) != '0) |=> ((map_q & $past(set_mask_i & clr_mask_i)) == '0));
   end
endmodule

// File: rtl/cgm_enable_out.sv
module cgm_enable_out #(
   parameter int unsigned MAP_W   = 64,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [MAP_W-1:0] map_i,
   output logic [MAP_W-1:0] clk_en_o
);
   if (OUT_REG) begin : g_reg
      logic [MAP_W-1:0] en_q;
      always_ff @(posedge clk) begin
         if (!rst_n) en_q <= '1;
         else        en_q <= ~map_i;
      end
      assign clk_en_o = en_q;

      assert_en_follows_R10 : assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (clk_en_o == ~$past(map_i)));
   end else begin : g_comb
      assign clk_en_o = ~map_i;
   end
endmodule

// File: rtl/clkgate_map_ctl.sv
module clkgate_map_ctl #(
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned MAP_W    = 64,
   parameter bit          CLR_WINS = 1'b1,
   parameter bit          OUT_REG  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W/8-1:0] bus_be,
   input  logic              bus_we,
   input  logic              bus_sup,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [MAP_W-1:0]  clk_en,
   output logic              acc_err
);
   import cgm_pkg::*;

   localparam int unsigned N_WORDS = MAP_W / DATA_W;
   localparam int unsigned BE_W    = DATA_W / 8;
   localparam int unsigned IDX_W   = $clog2(MAP_W);
   localparam int unsigned ALL_BIT = IDX_W;
   localparam int unsigned CMD_ADR = N_WORDS;
   localparam int unsigned SET_LSB = SET_LANE * CMD_W;
   localparam int unsigned CLR_LSB = CLR_LANE * CMD_W;

   initial begin
      if (DATA_W < 16 || DATA_W % 8 != 0)
         $error("clkgate_map_ctl: DATA_W must be whole bytes, at least two");
      if (MAP_W > 128)
         $error("clkgate_map_ctl: index plus flag must fit in a byte");
      if ((1 << ADDR_W) <= CMD_ADR)
         $error("clkgate_map_ctl: ADDR_W too small for the register map");
   end

   // Address decode
   reg_sel_e          sel;
   logic [N_WORDS-1:0] word_hit;
   always_comb begin
      sel = RS_NONE;
      if (32'(bus_addr) < N_WORDS)       sel = RS_MAP;
      else if (32'(bus_addr) == CMD_ADR) sel = RS_CMD;
      for (int w = 0; w < N_WORDS; w++)
         word_hit[w] = (32'(bus_addr) == w);
   end

   logic wr_ok;
   logic user_wr;
   assign wr_ok   = bus_we & bus_sup;
   assign user_wr = bus_we & ~bus_sup & (sel != RS_NONE);

   logic [N_WORDS-1:0] map_wr_en;
   assign map_wr_en = (wr_ok && sel == RS_MAP) ? word_hit : '0;

   logic cmd_wr;
   assign cmd_wr = wr_ok & (sel == RS_CMD);

   logic [MAP_W-1:0] set_mask, clr_mask, map_q;

   cgm_cmd_decode #(.MAP_W(MAP_W), .CMD_W(CMD_W)) u_set_dec (
      .en_i   (cmd_wr & bus_be[SET_LANE]),
      .cmd_i  (bus_wdata[SET_LSB +: CMD_W]),
      .mask_o (set_mask)
   );

   cgm_cmd_decode #(.MAP_W(MAP_W), .CMD_W(CMD_W)) u_clr_dec (
      .en_i   (cmd_wr & bus_be[CLR_LANE]),
      .cmd_i  (bus_wdata[CLR_LSB +: CMD_W]),
      .mask_o (clr_mask)
   );

   cgm_map_reg #(.MAP_W(MAP_W), .WORD_W(DATA_W), .CLR_WINS(CLR_WINS)) u_map (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_word_en_i (map_wr_en),
      .wr_be_i      (bus_be),
      .wr_data_i    (bus_wdata),
      .set_mask_i   (set_mask),
      .clr_mask_i   (clr_mask),
      .map_o        (map_q)
   );

   cgm_enable_out #(.MAP_W(MAP_W), .OUT_REG(OUT_REG)) u_en (
      .clk      (clk),
      .rst_n    (rst_n),
      .map_i    (map_q),
      .clk_en_o (clk_en)
   );

   // Read path: map words only, command word and the rest read zero
   always_comb begin
      bus_rdata = '0;
      for (int w = 0; w < N_WORDS; w++)
         if (word_hit[w]) bus_rdata = map_q[w*DATA_W +: DATA_W];
   end

   logic err_q;
   always_ff @(posedge clk) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= user_wr;
   end
   assign acc_err = err_q;

   // Checks
   assert_set_one_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && bus_be[SET_LANE] && !bus_be[CLR_LANE] && !bus_wdata[SET_LSB+ALL_BIT])
      |=> map_q[$past(bus_wdata[SET_LSB +: IDX_W])]);

   assert_clr_one_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && bus_be[CLR_LANE] && !bus_wdata[CLR_LSB+ALL_BIT])
      |=> !map_q[$past(bus_wdata[CLR_LSB +: IDX_W])]);

   assert_clr_all_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && bus_be[CLR_LANE] && bus_wdata[CLR_LSB+ALL_BIT]) |=> (map_q == '0));

   assert_user_ignored_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !bus_sup) |=> $stable(map_q));

   assert_err_pulse_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      user_wr |=> acc_err);

   assert_err_cause_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      acc_err |-> $past(bus_we && !bus_sup));

   assert_cmd_reads_zero_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (32'(bus_addr) >= CMD_ADR) |-> (bus_rdata == '0));
endmodule

// File: tb/sim_clkgate_map_ctl.sv
`timescale 1ns/1ps
module sim_clkgate_map_ctl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [3:0]  bus_be = '0;
   logic        bus_we = 1'b0;
   logic        bus_sup = 1'b0;
   logic [31:0] bus_rdata;
   logic [63:0] clk_en;
   logic        acc_err;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   clkgate_map_ctl u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_be(bus_be), .bus_we(bus_we), .bus_sup(bus_sup),
      .bus_rdata(bus_rdata), .clk_en(clk_en), .acc_err(acc_err)
   );

   typedef struct packed {
      logic [3:0]  addr;
      logic [3:0]  be;
      logic [31:0] data;
      logic        sup;
      logic [31:0] lo;
      logic [31:0] hi;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [0:NV-1] = '{
      '{4'd2, 4'b0001, 32'h0000_0005, 1'b1, 32'h0000_0020, 32'h0000_0000}, // R2 set idx 5
      '{4'd2, 4'b0001, 32'h0000_0028, 1'b1, 32'h0000_0020, 32'h0000_0100}, // R2 set idx 40
      '{4'd2, 4'b0001, 32'h0000_00BF, 1'b1, 32'h0000_0020, 32'h8000_0100}, // R5 bit7 ignored, idx 63
      '{4'd2, 4'b0010, 32'h0000_0500, 1'b1, 32'h0000_0000, 32'h8000_0100}, // R3 clear idx 5
      '{4'd2, 4'b0001, 32'h0000_004A, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF}, // R4 set all
      '{4'd2, 4'b0011, 32'h0000_0000, 1'b1, 32'hFFFF_FFFE, 32'hFFFF_FFFF}, // R9 clear wins idx 0
      '{4'd2, 4'b0010, 32'h0000_4000, 1'b0, 32'hFFFF_FFFE, 32'hFFFF_FFFF}, // R8 user cmd dropped
      '{4'd0, 4'b1111, 32'h1234_5678, 1'b1, 32'h1234_5678, 32'hFFFF_FFFF}, // R7 direct low
      '{4'd1, 4'b0100, 32'h00AB_0000, 1'b1, 32'h1234_5678, 32'hFFAB_FFFF}, // R7 one byte high
      '{4'd2, 4'b0010, 32'h0000_C000, 1'b1, 32'h0000_0000, 32'h0000_0000}, // R4 clear all, bit7 set
      '{4'd2, 4'b0011, 32'h0000_0340, 1'b1, 32'hFFFF_FFF7, 32'hFFFF_FFFF}, // R9 all set, clear idx 3
      '{4'd2, 4'b0001, 32'h0000_4003, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF}, // R5 clear lane disabled
      '{4'd2, 4'b0010, 32'h0000_2140, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFD}, // R5 set lane disabled, clear 33
      '{4'd0, 4'b1111, 32'h0000_0000, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFD}, // R8 user map write dropped
      '{4'd0, 4'b0000, 32'h0000_0000, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFD}  // R7 no byte enabled
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [3:0] a, input logic [3:0] be,
                           input logic [31:0] d, input logic sup);
      @(negedge clk);
      bus_addr = a; bus_be = be; bus_wdata = d; bus_sup = sup; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; bus_sup = 1'b1; bus_be = '0;
   endtask

   task automatic read_word(input logic [3:0] a, output logic [31:0] v);
      bus_addr = a;
      #1;
      v = bus_rdata;
   endtask

   initial begin : watchdog
      #4_000_000;
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] lo, hi;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      read_word(4'd0, lo);
      read_word(4'd1, hi);
      check("R1 map", {hi, lo}, 64'h0);
      check("R1 clk_en", clk_en, {64{1'b1}});
      check("R1 acc_err", {63'b0, acc_err}, 64'h0);

      for (int i = 0; i < NV; i++) begin
         do_write(VECS[i].addr, VECS[i].be, VECS[i].data, VECS[i].sup);
         // R8: error pulse only after user writes
         check("R8 acc_err", {63'b0, acc_err}, {63'b0, ~VECS[i].sup});
         read_word(4'd0, lo);
         read_word(4'd1, hi);
         check($sformatf("R2-vector %0d map", i), {hi, lo}, {VECS[i].hi, VECS[i].lo});
      end

      // R8 pulse lasts one cycle
      do_write(4'd1, 4'b1111, 32'h0, 1'b0);
      check("R8 pulse high", {63'b0, acc_err}, 64'h1);
      @(negedge clk);
      check("R8 pulse low", {63'b0, acc_err}, 64'h0);

      // R6 command word and unused addresses read zero
      read_word(4'd2, lo);
      check("R6 cmd read", {32'h0, lo}, 64'h0);
      read_word(4'd3, lo);
      check("R6 unused read", {32'h0, lo}, 64'h0);
      read_word(4'd1, hi);
      check("R6 high word", {32'h0, hi}, 64'h0000_0000_FFFF_FFFD);

      // R10 enables track the inverted map one cycle late
      check("R10 steady", clk_en, 64'h0000_0002_0000_0000);
      do_write(4'd2, 4'b0010, 32'h0000_4000, 1'b1);
      check("R10 before", clk_en, 64'h0000_0002_0000_0000);
      @(negedge clk);
      check("R10 after", clk_en, {64{1'b1}});
      read_word(4'd0, lo);
      read_word(4'd1, hi);
      check("R4 clear all", {hi, lo}, 64'h0);

      // R2 single set leaves neighbours alone, visible on clk_en
      do_write(4'd2, 4'b0001, 32'h0000_0020, 1'b1);
      @(negedge clk);
      check("R2 idx 32 enable", clk_en, ~(64'h1 << 32));

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule